// File: doc/BRIEF.md
# Sampled Angle and Velocity Serial Readout Port

This block sits between a shaft-angle tracking loop and a host controller. The tracking loop supplies a live 12-bit angle and a live 12-bit velocity every clock. A falling edge on an active-low sample strobe freezes both values into holding registers. The host can then fetch either frozen word over a three-wire serial link made of an active-low read/frame strobe, a host-driven serial clock and a serial data line, with an active-low chip select gating the transfer.

Each transfer is a 16-bit frame. The selected data word comes first, MSB first. Next comes a bit that tells which word was chosen. Then come two fault flags, a degraded-signal flag and a lost-tracking flag, which are frozen at the start of the read. The frame ends in a parity bit that makes the number of ones odd. The angle word is unsigned: zero means 0 degrees and all ones means one LSB short of a full turn. The velocity word is two's complement, with its sign in the MSB.

All strobe and clock pins from the host are brought into the system clock domain through a synchronizer, and their edges are detected there. The whole block therefore runs on one clock. The data output has a separate enable line. The pad is driven only while the enable is high, and it is high impedance otherwise.

Top module: `angle_serial_port`

## Requirements
- R1: A falling edge on `sampleN` copies `angleIn` into the position holding register and `velIn` into the velocity holding register, both in the same cycle.
- R2: A falling edge on `rdN` while `csN` is low loads a fresh frame and raises `sdoOe`. A falling edge on `rdN` while `csN` is high loads nothing, and `sdoOe` stays low.
- R3: Frame layout, with bit 15 sent first: bits 15..4 hold the selected 12-bit word, bit 3 holds the select value (1 = position), bit 2 holds `degradeIn` and bit 1 holds `trackLossIn`.
- R4: Bit 0 of the frame is set so that the 16-bit frame holds an odd number of ones.
- R5: Frame bit 15 is on `sdo` before the first `sclk` falling edge. Each `sclk` rising edge moves the next lower bit onto `sdo`, ready for the host at the following falling edge.
- R6: Once all 16 bits have been shifted out, further `sclk` rising edges while `rdN` stays low put zeros on `sdo`.
- R7: A rising edge on `rdN` drops `sdoOe`. After reset, `sdoOe` is low.
- R8: `selPos`, `degradeIn` and `trackLossIn` are taken when `rdN` falls. Later changes during the same frame do not alter the bits on `sdo`.
- R9: A change on `angleIn` or `velIn` with no new sample strobe does not change the word that a later read returns.
- R10: A velocity word is framed unchanged as two's complement, so a negative velocity appears with bit 15 of the frame set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| angleIn | input | 12 | Live unsigned angle from the tracking loop |
| velIn | input | 12 | Live two's complement velocity from the tracking loop |
| degradeIn | input | 1 | Live degraded-signal fault flag |
| trackLossIn | input | 1 | Live lost-tracking fault flag |
| sampleN | input | 1 | Active-low sample strobe; its falling edge freezes angle and velocity |
| selPos | input | 1 | Word select: 1 = position, 0 = velocity |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read/frame strobe |
| sclk | input | 1 | Host serial clock, idle high |
| sdo | output | 1 | Serial data bit |
| sdoOe | output | 1 | Output driver enable for `sdo`; the pad is high impedance while this is low |

## Verification
Frames are read with position and velocity words chosen so that different patterns are told apart. An all-zero word with clear flags forces a parity of one. An all-ones word with both flags set forces a parity of zero. A negative velocity shows that the sign passes through unchanged. Further reads check what must stay fixed: a live value changed with no new sample, and select and flag pins flipped in the middle of a frame, must not alter the frame. Reads that run past sixteen clocks show the zero fill. A read with chip select high shows that the driver stays off. A queue-based model is compared against `sdo` and `sdoOe` on every clock, so a shift that comes one edge early or late is caught as well as a wrong frame.

// File: rtl/angle_serial_pkg.sv
package angle_serial_pkg;

  // Strobes from the edge-detect control to the frame datapath
  typedef struct packed {
    logic captureSample;  // sample strobe fell
    logic loadFrame;      // read strobe fell with chip select low
    logic clearOut;       // read strobe rose
    logic shiftBit;       // serial clock rose
  } ctrlStrobes_t;

endpackage

// File: rtl/angle_serial_sync.sv
module angle_serial_sync #(
  parameter int WIDTH     = 4,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] curOut,
  output logic [WIDTH-1:0] prevOut
);

  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stageQ [STAGES];
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= IDLE_VAL;
      prevQ <= IDLE_VAL;
    end else begin
      stageQ[0] <= rawIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
      prevQ <= stageQ[LAST];
    end
  end

  assign curOut  = stageQ[LAST];
  assign prevOut = prevQ;

endmodule

// File: rtl/angle_serial_ctrl.sv
module angle_serial_ctrl
  import angle_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleN,
  input  logic         rdN,
  input  logic         csN,
  input  logic         sclk,
  output ctrlStrobes_t strb
);

  localparam int PIN_COUNT = 4;
  localparam int SAMPLE_BIT = 3;
  localparam int RD_BIT = 2;
  localparam int CS_BIT = 1;
  localparam int SCLK_BIT = 0;

  logic [PIN_COUNT-1:0] pinCur;
  logic [PIN_COUNT-1:0] pinPrev;
  logic [PIN_COUNT-1:0] pinFell;
  logic [PIN_COUNT-1:0] pinRose;

  angle_serial_sync #(
    .WIDTH   (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .IDLE_VAL('1)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({sampleN, rdN, csN, sclk}),
    .curOut (pinCur),
    .prevOut(pinPrev)
  );

  assign pinFell = pinPrev & ~pinCur;
  assign pinRose = ~pinPrev & pinCur;

  always_comb begin
    strb = '0;
    strb.captureSample = pinFell[SAMPLE_BIT];
    strb.loadFrame     = pinFell[RD_BIT] & ~pinCur[CS_BIT];
    strb.clearOut      = pinRose[RD_BIT];
    strb.shiftBit      = pinRose[SCLK_BIT];
  end

endmodule

// File: rtl/angle_serial_datapath.sv
module angle_serial_datapath
  import angle_serial_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [DATA_W-1:0] angleIn,
  input  logic [DATA_W-1:0] velIn,
  input  logic              degradeIn,
  input  logic              trackLossIn,
  input  logic              selPos,
  output logic              sdo,
  output logic              sdoOe
);

  localparam int STATUS_W = 3;
  localparam int FRAME_W  = DATA_W + STATUS_W + 1;
  localparam int UPPER_W  = FRAME_W - 1;

  logic [DATA_W-1:0]  posHold;
  logic [DATA_W-1:0]  velHold;
  logic [FRAME_W-1:0] shiftQ;
  logic               oeQ;
  logic [DATA_W-1:0]  selWord;
  logic [UPPER_W-1:0] frameUpper;
  logic               parityBit;
  logic               shiftNow;

  always_comb begin
    selWord    = selPos ? posHold : velHold;
    frameUpper = {selWord, selPos, degradeIn, trackLossIn};
    parityBit  = ~(^frameUpper);
    shiftNow   = strb.shiftBit & oeQ & ~strb.loadFrame & ~strb.clearOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posHold <= '0;
      velHold <= '0;
    end else if (strb.captureSample) begin
      posHold <= angleIn;
      velHold <= velIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      oeQ    <= 1'b0;
    end else if (strb.loadFrame) begin
      shiftQ <= {frameUpper, parityBit};
      oeQ    <= 1'b1;
    end else if (strb.clearOut) begin
      oeQ <= 1'b0;
    end else if (shiftNow) begin
      shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo   = shiftQ[FRAME_W-1];
  assign sdoOe = oeQ;

  // R1
  capture_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureSample |=> (posHold == $past(angleIn)) && (velHold == $past(velIn)));

  // R4
  odd_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |=> (^shiftQ) && oeQ);

  // R8
  status_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFrame |=> shiftQ[3:1] == $past({selPos, degradeIn, trackLossIn}));

  // R5
  shift_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftNow |=> shiftQ[FRAME_W-1] == $past(shiftQ[FRAME_W-2]));

  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftNow |=> !shiftQ[0]);

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearOut && !strb.loadFrame) |=> !oeQ);

endmodule

// File: rtl/angle_serial_port.sv
module angle_serial_port
  import angle_serial_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] angleIn,
  input  logic [DATA_W-1:0] velIn,
  input  logic              degradeIn,
  input  logic              trackLossIn,
  input  logic              sampleN,
  input  logic              selPos,
  input  logic              csN,
  input  logic              rdN,
  input  logic              sclk,
  output logic              sdo,
  output logic              sdoOe
);

  ctrlStrobes_t strb;

  angle_serial_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sampleN(sampleN),
    .rdN    (rdN),
    .csN    (csN),
    .sclk   (sclk),
    .strb   (strb)
  );

  angle_serial_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .angleIn    (angleIn),
    .velIn      (velIn),
    .degradeIn  (degradeIn),
    .trackLossIn(trackLossIn),
    .selPos     (selPos),
    .sdo        (sdo),
    .sdoOe      (sdoOe)
  );

endmodule

// File: tb/angle_serial_port_tb.sv
module angle_serial_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] angleIn = '0;
  logic [11:0] velIn = '0;
  logic        degradeIn = 1'b0;
  logic        trackLossIn = 1'b0;
  logic        sampleN = 1'b1;
  logic        selPos = 1'b1;
  logic        csN = 1'b0;
  logic        rdN = 1'b1;
  logic        sclk = 1'b1;
  logic        sdo;
  logic        sdoOe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  angle_serial_port u_dut (
    .clk(clk), .rstN(rstN), .angleIn(angleIn), .velIn(velIn),
    .degradeIn(degradeIn), .trackLossIn(trackLossIn), .sampleN(sampleN),
    .selPos(selPos), .csN(csN), .rdN(rdN), .sclk(sclk),
    .sdo(sdo), .sdoOe(sdoOe)
  );

  // Reference model: pin history queue, held words and a queue of frame bits
  logic [3:0]  hist[$];
  logic [11:0] mPos, mVel;
  bit          mOe;
  bit          mBits[$];

  function automatic logic [15:0] expFrame(logic [11:0] w, logic s, logic d, logic l);
    logic [14:0] up;
    int ones;
    up = {w, s, d, l};
    ones = 0;
    for (int i = 0; i < 15; i++) ones += up[i];
    return {up, (ones % 2 == 0) ? 1'b1 : 1'b0};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{4'hF, 4'hF, 4'hF};
      mPos = '0; mVel = '0; mOe = 0; mBits = {};
    end else begin
      logic [3:0] oldV, newV;
      logic [15:0] f;
      oldV = hist[2];
      newV = hist[1];
      if (oldV[2] && !newV[2] && !newV[1]) begin
        f = expFrame(selPos ? mPos : mVel, selPos, degradeIn, trackLossIn);
        mBits = {};
        for (int i = 15; i >= 0; i--) mBits.push_back(f[i]);
        mOe = 1;
      end else if (!oldV[2] && newV[2]) begin
        mOe = 0;
      end else if (!oldV[0] && newV[0] && mOe) begin
        if (mBits.size() > 0) void'(mBits.pop_front());
      end
      if (oldV[3] && !newV[3]) begin
        mPos = angleIn; mVel = velIn;
      end
      hist.push_front({sampleN, rdN, csN, sclk});
      if (hist.size() > 3) void'(hist.pop_back());
    end
  end

  // Cycle compare against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expBit;
      checks++;
      if (sdoOe !== mOe) begin
        failures++;
        $display("FAIL R2/R7 model enable: got %0b exp %0b at %0t", sdoOe, mOe, $time);
      end
      if (mOe) begin
        expBit = (mBits.size() > 0) ? mBits[0] : 1'b0;
        checks++;
        if (sdo !== expBit) begin
          failures++;
          $display("FAIL R5/R6 model data: got %0b exp %0b at %0t", sdo, expBit, $time);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic pulseSample();
    sampleN = 1'b0; tick(HALF);
    sampleN = 1'b1; tick(HALF);
  endtask

  task automatic hostRead(input logic sel, input int extra, input bit disturb,
                          output logic [15:0] got, output int zeroBad);
    selPos = sel; tick(4);
    rdN = 1'b0; tick(HALF);
    if (disturb) begin
      selPos = ~selPos; degradeIn = ~degradeIn; trackLossIn = ~trackLossIn;
      angleIn = ~angleIn;
    end
    zeroBad = 0;
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; tick(HALF);
      got[15-i] = sdo;
      sclk = 1'b1; tick(HALF);
    end
    for (int i = 0; i < extra; i++) begin
      sclk = 1'b0; tick(HALF);
      if (sdo !== 1'b0) zeroBad++;
      sclk = 1'b1; tick(HALF);
    end
    rdN = 1'b1; tick(HALF);
  endtask

  initial begin
    logic [15:0] got;
    int zb;
    tick(5);
    rstN = 1'b1;
    tick(3);
    // R7: enable off after reset
    check("R7 reset enable", sdoOe, 0);

    // R1 R3 R4: position frame
    angleIn = 12'hABC; velIn = 12'h123; degradeIn = 1; trackLossIn = 0;
    pulseSample();
    hostRead(1'b1, 0, 0, got, zb);
    check("R1/R3/R4 position frame", got, expFrame(12'hABC, 1, 1, 0));

    // R1 R3: velocity frame from same sample
    hostRead(1'b0, 0, 0, got, zb);
    check("R1/R3 velocity frame", got, expFrame(12'h123, 0, 1, 0));

    // R10: negative velocity keeps sign in MSB
    velIn = 12'h9F3; degradeIn = 0; trackLossIn = 1;
    pulseSample();
    hostRead(1'b0, 0, 0, got, zb);
    check("R10 negative velocity frame", got, expFrame(12'h9F3, 0, 0, 1));
    check("R10 sign bit", got[15], 1);

    // R4: all-zero upper bits gives parity 1
    angleIn = 12'h000; velIn = 12'h000; degradeIn = 0; trackLossIn = 0;
    pulseSample();
    hostRead(1'b0, 0, 0, got, zb);
    check("R4 parity on zero word", got, 16'h0001);

    // R4: fifteen ones gives parity 0
    angleIn = 12'hFFF; degradeIn = 1; trackLossIn = 1;
    pulseSample();
    hostRead(1'b1, 0, 0, got, zb);
    check("R4 parity on full word", got, 16'hFFFE);

    // R9: live change without sample is not seen
    angleIn = 12'h5A5;
    hostRead(1'b1, 0, 0, got, zb);
    check("R9 held position", got, 16'hFFFE);

    // R6: zeros beyond sixteen bits
    angleIn = 12'h7E1; degradeIn = 0; trackLossIn = 0;
    pulseSample();
    hostRead(1'b1, 6, 0, got, zb);
    check("R6 frame before fill", got, expFrame(12'h7E1, 1, 0, 0));
    check("R6 zero fill bits", zb, 0);

    // R8: select and flags flipped mid-frame are ignored
    hostRead(1'b1, 0, 1, got, zb);
    check("R8 frozen status", got, expFrame(12'h7E1, 1, 0, 0));
    angleIn = ~angleIn; selPos = 1'b1; degradeIn = 0; trackLossIn = 0;

    // R5: MSB before first clock fall, next bit after one rising edge
    angleIn = 12'h800;
    pulseSample();
    selPos = 1'b1; tick(4);
    rdN = 1'b0; tick(HALF);
    check("R5 MSB before first edge", sdo, 1);
    sclk = 1'b0; tick(HALF);
    sclk = 1'b1; tick(HALF);
    check("R5 second bit after rise", sdo, 0);
    rdN = 1'b1; tick(HALF);
    // R7: release drops enable
    check("R7 enable after release", sdoOe, 0);

    // R2: chip select high blocks the load
    csN = 1'b1; tick(4);
    rdN = 1'b0; tick(HALF);
    check("R2 enable with chip select high", sdoOe, 0);
    sclk = 1'b0; tick(HALF);
    sclk = 1'b1; tick(HALF);
    check("R2 enable still low after clock", sdoOe, 0);
    rdN = 1'b1; tick(HALF);
    csN = 1'b0; tick(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule